// File: doc/BRIEF.md
# Timebase Interrupt and Beep Generator

This peripheral sits on a small byte-wide register bus and provides two timing services from the main clock. A timebase counter raises a sticky timeout flag every time a software-selected number of clock cycles has elapsed. The flag can drive an interrupt line, and software acknowledges it simply by reading the control register. A separate divider produces a roughly 50% duty square wave on a beep pin, with three pitches and an off setting chosen through a second register.

Because any read of the control register clears the flag, firmware that read-modify-writes that register will consume a pending timeout. The block guarantees that a timeout that lands on the very cycle of a clearing read is never lost. Changing the timebase selection restarts its counter, and changing the beep selection restarts the divider from a low level, so each new setting starts with a full period.

Top module: `tick_beep_unit`

## Requirements
- R1: After reset both registers read 00h, `irq` is 0 and `beep_out` is 0.
- R2: With timebase code 00, 01, 10 or 11 in control bits 3:2, the timeout flag is set once every TB_PER0, TB_PER1, TB_PER2 or TB_PER3 clock cycles (defaults 4000, 8000, 20000, 40000), the first time that many cycles after the counter restarts.
- R3: The control register (address 0) reads bit 0 = timeout flag, bit 1 = interrupt enable, bits 3:2 = timebase code, bit 4 = slow-mode select, bits 7:5 = 0; bits 4:1 are writable and a write to bit 0 has no effect.
- R4: A read of address 0 returns the flag as it was before the read and clears it at that clock edge; the flag otherwise stays set until read.
- R5: If the flag is being set by a timeout on the same edge as a clearing read, the flag remains set afterwards.
- R6: A write that changes the timebase code restarts the counter from zero; a write that leaves the code unchanged does not disturb the counter.
- R7: `irq` is high exactly while both the timeout flag and the interrupt enable are 1.
- R8: The beep register (address 1) holds the beep code in bits 1:0; bits 7:2 read as 0 whatever is written.
- R9: Beep code 00 holds `beep_out` low; codes 01, 10 and 11 give a square wave whose high and low phases each last BEEP_HALF1, BEEP_HALF2 or BEEP_HALF3 cycles (defaults 2000, 4000, 8000, roughly 2 kHz, 1 kHz and 500 Hz at 8 MHz).
- R10: A write that changes the beep code restarts the divider: `beep_out` is low from that edge and first rises exactly one half period later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 1 | Register select: 0 control, 1 beep |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| irq | output | 1 | Timeout interrupt request |
| beep_out | output | 1 | Square-wave beep pin |

## Verification
The bench uses short periods and sweeps every timebase and beep code, checking the timeout exactly one cycle before and at each expected period boundary, so a counter that wraps one cycle early or late, or that restarts on a write which left the code unchanged, is caught. It times a clearing read to land on the very edge of a new timeout; a design that let the clear win would drop that event and `irq` would fall. It writes the enable off while a timeout occurs, so an interrupt not gated by the enable shows up high. Every beep sample over two full periods is compared with the expected phase, and a mid-wave code change exposes a divider that keeps its old count or level.

// File: rtl/tick_beep_pkg.sv
package tick_beep_pkg;

    localparam int DEF_TB_PER0   = 4000;
    localparam int DEF_TB_PER1   = 8000;
    localparam int DEF_TB_PER2   = 20000;
    localparam int DEF_TB_PER3   = 40000;
    localparam int DEF_BEEP_HALF1 = 2000;
    localparam int DEF_BEEP_HALF2 = 4000;
    localparam int DEF_BEEP_HALF3 = 8000;
    localparam int DEF_CNT_W      = 16;

    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_BEEP = 1'b1;

    typedef struct packed {
        logic       slow;
        logic [1:0] tb_sel;
        logic       ie;
    } ctrl_t;

    typedef enum logic [1:0] {
        BEEP_OFF  = 2'b00,
        BEEP_FAST = 2'b01,
        BEEP_MID  = 2'b10,
        BEEP_SLOW = 2'b11
    } beep_sel_e;

    function automatic logic [7:0] pack_ctrl(input ctrl_t c, input logic flag);
        return {3'b000, c.slow, c.tb_sel, c.ie, flag};
    endfunction

    function automatic logic [7:0] pack_beep(input beep_sel_e s);
        return {6'b000000, s};
    endfunction

    function automatic ctrl_t unpack_ctrl(input logic [7:0] d);
        ctrl_t c;
        c.slow   = d[4];
        c.tb_sel = d[3:2];
        c.ie     = d[1];
        return c;
    endfunction

endpackage

// File: rtl/tbu_regs.sv
module tbu_regs
    import tick_beep_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       addr,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wdata,
    input  logic       tick,
    output logic [7:0] rdata,
    output ctrl_t      ctrl,
    output beep_sel_e  beep_sel,
    output logic       flag,
    output logic       tb_restart,
    output logic       beep_restart
);

    ctrl_t     ctrl_q;
    beep_sel_e beep_q;
    logic      flag_q;
    logic      wr_ctrl;
    logic      wr_beep;
    logic      rd_clr;
    ctrl_t     ctrl_new;
    logic      unused_wbits;

    assign unused_wbits = ^wdata[7:5];

    assign wr_ctrl  = wr_en && (addr == ADDR_CTRL);
    assign wr_beep  = wr_en && (addr == ADDR_BEEP);
    assign rd_clr   = rd_en && (addr == ADDR_CTRL);
    assign ctrl_new = unpack_ctrl(wdata);

    assign tb_restart   = wr_ctrl && (ctrl_new.tb_sel != ctrl_q.tb_sel);
    assign beep_restart = wr_beep && (wdata[1:0] != beep_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            beep_q <= BEEP_OFF;
        end else begin
            if (wr_ctrl) begin
                ctrl_q <= ctrl_new;
            end
            if (wr_beep) begin
                beep_q <= beep_sel_e'(wdata[1:0]);
            end
        end
    end

    // A timeout on the clearing edge wins so that no event is dropped.
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= tick || (flag_q && !rd_clr);
        end
    end

    always_comb begin
        if (addr == ADDR_CTRL) begin
            rdata = pack_ctrl(ctrl_q, flag_q);
        end else begin
            rdata = pack_beep(beep_q);
        end
    end

    assign ctrl     = ctrl_q;
    assign beep_sel = beep_q;
    assign flag     = flag_q;

endmodule

// File: rtl/tbu_timebase.sv
module tbu_timebase
    import tick_beep_pkg::*;
#(
    parameter int TB_PER0 = DEF_TB_PER0,
    parameter int TB_PER1 = DEF_TB_PER1,
    parameter int TB_PER2 = DEF_TB_PER2,
    parameter int TB_PER3 = DEF_TB_PER3,
    parameter int CNT_W   = DEF_CNT_W
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] tb_sel,
    input  logic       restart,
    output logic       tick
);

    localparam logic [CNT_W-1:0] LAST0 = CNT_W'(TB_PER0 - 1);
    localparam logic [CNT_W-1:0] LAST1 = CNT_W'(TB_PER1 - 1);
    localparam logic [CNT_W-1:0] LAST2 = CNT_W'(TB_PER2 - 1);
    localparam logic [CNT_W-1:0] LAST3 = CNT_W'(TB_PER3 - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;
    logic             at_end;

    always_comb begin
        case (tb_sel)
            2'b00:   last = LAST0;
            2'b01:   last = LAST1;
            2'b10:   last = LAST2;
            default: last = LAST3;
        endcase
    end

    assign at_end = (cnt_q >= last);
    assign tick   = at_end && !restart;

    always_ff @(posedge clk) begin
        if (rst || restart || at_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/tbu_beep.sv
module tbu_beep
    import tick_beep_pkg::*;
#(
    parameter int BEEP_HALF1 = DEF_BEEP_HALF1,
    parameter int BEEP_HALF2 = DEF_BEEP_HALF2,
    parameter int BEEP_HALF3 = DEF_BEEP_HALF3,
    parameter int CNT_W      = DEF_CNT_W
) (
    input  logic      clk,
    input  logic      rst,
    input  beep_sel_e sel,
    input  logic      restart,
    output logic      beep_out
);

    localparam logic [CNT_W-1:0] HLAST1 = CNT_W'(BEEP_HALF1 - 1);
    localparam logic [CNT_W-1:0] HLAST2 = CNT_W'(BEEP_HALF2 - 1);
    localparam logic [CNT_W-1:0] HLAST3 = CNT_W'(BEEP_HALF3 - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] hlast;
    logic             tog_q;
    logic             running;
    logic             half_done;

    always_comb begin
        case (sel)
            BEEP_FAST: hlast = HLAST1;
            BEEP_MID:  hlast = HLAST2;
            BEEP_SLOW: hlast = HLAST3;
            default:   hlast = '0;
        endcase
    end

    assign running   = (sel != BEEP_OFF);
    assign half_done = (cnt_q >= hlast);

    always_ff @(posedge clk) begin
        if (rst || restart || !running) begin
            cnt_q <= '0;
            tog_q <= 1'b0;
        end else if (half_done) begin
            cnt_q <= '0;
            tog_q <= !tog_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign beep_out = tog_q && running;

endmodule

// File: rtl/tick_beep_unit.sv
module tick_beep_unit
    import tick_beep_pkg::*;
#(
    parameter int TB_PER0    = DEF_TB_PER0,
    parameter int TB_PER1    = DEF_TB_PER1,
    parameter int TB_PER2    = DEF_TB_PER2,
    parameter int TB_PER3    = DEF_TB_PER3,
    parameter int BEEP_HALF1 = DEF_BEEP_HALF1,
    parameter int BEEP_HALF2 = DEF_BEEP_HALF2,
    parameter int BEEP_HALF3 = DEF_BEEP_HALF3,
    parameter int CNT_W      = DEF_CNT_W
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       addr,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       irq,
    output logic       beep_out
);

    ctrl_t     ctrl;
    beep_sel_e beep_sel;
    logic      flag;
    logic      tick;
    logic      tb_restart;
    logic      beep_restart;

    tbu_regs u_regs (
        .clk          (clk),
        .rst          (rst),
        .addr         (addr),
        .wr_en        (wr_en),
        .rd_en        (rd_en),
        .wdata        (wdata),
        .tick         (tick),
        .rdata        (rdata),
        .ctrl         (ctrl),
        .beep_sel     (beep_sel),
        .flag         (flag),
        .tb_restart   (tb_restart),
        .beep_restart (beep_restart)
    );

    tbu_timebase #(
        .TB_PER0 (TB_PER0),
        .TB_PER1 (TB_PER1),
        .TB_PER2 (TB_PER2),
        .TB_PER3 (TB_PER3),
        .CNT_W   (CNT_W)
    ) u_tb (
        .clk     (clk),
        .rst     (rst),
        .tb_sel  (ctrl.tb_sel),
        .restart (tb_restart),
        .tick    (tick)
    );

    tbu_beep #(
        .BEEP_HALF1 (BEEP_HALF1),
        .BEEP_HALF2 (BEEP_HALF2),
        .BEEP_HALF3 (BEEP_HALF3),
        .CNT_W      (CNT_W)
    ) u_beep (
        .clk      (clk),
        .rst      (rst),
        .sel      (beep_sel),
        .restart  (beep_restart),
        .beep_out (beep_out)
    );

    assign irq = flag && ctrl.ie;

endmodule

// File: rtl/tbu_checker.sv
module tbu_checker
    import tick_beep_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      addr,
    input logic      rd_en,
    input logic      tick,
    input logic      flag,
    input logic      tb_restart,
    input logic      beep_restart,
    input beep_sel_e beep_sel,
    input logic      beep_out
);

    logic clr_rd;
    assign clr_rd = rd_en && (addr == ADDR_CTRL);

    AST_TICK_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        tick |=> flag); // R2

    AST_READ_CLEARS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (clr_rd && !tick) |=> !flag); // R4

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr_rd) |=> flag); // R4

    AST_COINCIDENT_KEEPS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (tick && clr_rd) |=> flag); // R5

    AST_RESTART_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        tb_restart |=> !tick); // R6

    AST_BEEP_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
        (beep_sel == BEEP_OFF) |-> !beep_out); // R9

    AST_BEEP_RESTART_LOW: assert property (@(posedge clk) disable iff (rst)
        beep_restart |=> !beep_out); // R10

endmodule

bind tick_beep_unit tbu_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .addr         (addr),
    .rd_en        (rd_en),
    .tick         (tick),
    .flag         (flag),
    .tb_restart   (tb_restart),
    .beep_restart (beep_restart),
    .beep_sel     (beep_sel),
    .beep_out     (beep_out)
);

// File: tb/sim_tick_beep_unit.sv
module sim_tick_beep_unit;

    localparam int CLK_NS = 10;
    localparam int P0 = 5;
    localparam int P1 = 8;
    localparam int P2 = 12;
    localparam int P3 = 20;
    localparam int H1 = 3;
    localparam int H2 = 4;
    localparam int H3 = 6;
    localparam int WATCHDOG_CYC = 50000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       addr = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq;
    logic       beep_out;

    int checks = 0;
    int errors = 0;

    tick_beep_unit #(
        .TB_PER0 (P0), .TB_PER1 (P1), .TB_PER2 (P2), .TB_PER3 (P3),
        .BEEP_HALF1 (H1), .BEEP_HALF2 (H2), .BEEP_HALF3 (H3),
        .CNT_W (8)
    ) u0 (
        .clk (clk), .rst (rst), .addr (addr), .wr_en (wr_en), .rd_en (rd_en),
        .wdata (wdata), .rdata (rdata), .irq (irq), .beep_out (beep_out)
    );

    always #(CLK_NS / 2) clk = ~clk;

    function automatic int period_of(input int k);
        case (k)
            0: return P0;
            1: return P1;
            2: return P2;
            default: return P3;
        endcase
    endfunction

    function automatic int half_of(input int c);
        case (c)
            1: return H1;
            2: return H2;
            default: return H3;
        endcase
    endfunction

    task automatic chk_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus_write(input logic a, input logic [7:0] d);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic a, output logic [7:0] d);
        rd_en = 1'b1;
        addr  = a;
        #1 d = rdata;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Compare beep_out with the ideal phase for 'cycles' samples after a restart.
    task automatic sweep_beep(input string req, input int h, input int cycles);
        int bad = 0;
        for (int n = 0; n < cycles; n++) begin
            if (int'(beep_out) != ((n / h) % 2)) bad++;
            step();
        end
        chk_eq(req, bad, 0);
    endtask

    initial begin
        #(CLK_NS * WATCHDOG_CYC);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int n;
        int p;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        chk_eq("R1 irq after reset", int'(irq), 0);
        chk_eq("R1 beep after reset", int'(beep_out), 0);
        bus_read(1'b0, d);
        chk_eq("R1 control reads 00h", int'(d), 0);
        bus_read(1'b1, d);
        chk_eq("R1 beep reg reads 00h", int'(d), 0);

        // R3 control field layout; bit 0 not writable, 7:5 read zero
        bus_write(1'b0, 8'hFF);
        bus_read(1'b0, d);
        chk_eq("R3 control readback bits 7:1", int'(d & 8'hFE), 8'h1E);
        chk_eq("R3 write to bit 0 ignored", int'(d[0]), 0);
        bus_write(1'b0, 8'h00);
        bus_read(1'b0, d);
        chk_eq("R3 control cleared", int'(d & 8'hFE), 0);

        // R2/R4/R5/R6/R7 sweep over all timebase codes
        for (int k = 0; k < 4; k++) begin
            p = period_of(k);
            bus_write(1'b0, 8'(((k + 1) % 4) << 2));
            bus_write(1'b0, 8'(k << 2));           // restart edge, n = 0
            n = 0;
            bus_read(1'b0, d);
            n = 1;
            bus_write(1'b0, 8'((k << 2) | 2));     // same code, enable on
            n = 2;
            while (n < p - 1) begin step(); n++; end
            chk_eq($sformatf("R6 no early timeout code %0d", k), int'(irq), 0);
            step(); n++;
            chk_eq($sformatf("R2 first timeout code %0d", k), int'(irq), 1);
            bus_read(1'b0, d);
            n++;
            chk_eq($sformatf("R4 read returns set flag code %0d", k), int'(d[0]), 1);
            chk_eq($sformatf("R4 read clears flag code %0d", k), int'(irq), 0);
            while (n < 2 * p - 1) begin step(); n++; end
            chk_eq($sformatf("R2 quiet before second period code %0d", k), int'(irq), 0);
            step(); n++;
            chk_eq($sformatf("R2 second timeout code %0d", k), int'(irq), 1);
            while (n < 3 * p - 1) begin step(); n++; end
            bus_read(1'b0, d);                      // clear on the timeout edge
            n++;
            chk_eq($sformatf("R5 flag kept on coincident read code %0d", k), int'(irq), 1);
            bus_read(1'b0, d);
            n++;
            chk_eq($sformatf("R4 flag cleared by later read code %0d", k), int'(irq), 0);
            bus_write(1'b0, 8'(k << 2));           // enable off, same code
            n++;
            while (n < 4 * p) begin step(); n++; end
            chk_eq($sformatf("R7 irq low with enable off code %0d", k), int'(irq), 0);
            bus_read(1'b0, d);
            chk_eq($sformatf("R7 flag set while irq low code %0d", k), int'(d[0]), 1);
        end

        // R8 beep register reserved bits
        bus_write(1'b1, 8'hFF);
        bus_read(1'b1, d);
        chk_eq("R8 beep reg reads 03h after FFh", int'(d), 3);

        // R9 off holds low
        bus_write(1'b1, 8'h00);
        begin
            int hi = 0;
            for (int i = 0; i < 4 * H3; i++) begin
                if (beep_out) hi++;
                step();
            end
            chk_eq("R9 beep off samples high", hi, 0);
        end

        // R9/R10 each code started from off
        for (int c = 1; c < 4; c++) begin
            bus_write(1'b1, 8'h00);
            bus_write(1'b1, 8'(c));
            sweep_beep($sformatf("R9 R10 beep code %0d mismatches", c), half_of(c), 4 * half_of(c));
        end

        // R10 change of code mid-wave restarts low
        bus_write(1'b1, 8'h00);
        bus_write(1'b1, 8'h01);
        repeat (H1 + 1) step();
        chk_eq("R10 wave high before change", int'(beep_out), 1);
        bus_write(1'b1, 8'h03);
        sweep_beep("R10 mid-wave change mismatches", H3, 4 * H3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule